// File: doc/BRIEF.md
# Triple Down-Counting Timer with Input Capture

This peripheral holds three independent down-counters, numbered 0 to 2. A shared start register gates each one, and a single count-enable input paces all three. Software programs each channel through a small word-addressed register bus. Each channel has three registers: a reload constant, the live counter, and a control word that holds the underflow flag and its interrupt enable. A channel that counts down past zero loads its reload constant again and raises its underflow flag. Channel 2 has one more register. On a rising edge of an external capture pin, it latches the channel 2 count and raises its own capture flag.

The block produces four interrupt requests. Each request is the AND of a flag and its enable. A fixed priority encoder turns the pending requests into one code for the system's interrupt controller. Writes take effect at once and do not wait for the counting. Software must therefore clear a channel's start bit before it writes that channel's registers. Reads are registered. A read that coincides with a decrement returns the count from before that decrement.

Top module: `cdt_timer_unit`

## Requirements
- R1: After reset, all start bits, flags and enables read 0. Every counter and reload register reads all ones, the capture register reads 0, irq_req is 0 and irq_code is 0.
- R2: Address 0 holds the start bits, with bit i controlling channel i. Channel i has its reload register at 1+3*i, its counter at 2+3*i and its control word at 3+3*i. A counter decreases by one in each cycle in which both `tick` and its start bit are 1. Otherwise it holds its value, unless a bus write loads it.
- R3: When a channel counts while its counter is 0, the counter loads the channel's reload value and the underflow flag (control bit 0) becomes 1.
- R4: A flag is cleared only by writing 0 to its control bit. Writing 1 to a flag bit leaves the flag unchanged, and so cannot set it.
- R5: irq_req[i] for channel i is 1 exactly when that channel's underflow flag and its enable (control bit 1) are both 1. A set flag with the enable at 0 raises no request.
- R6: A rising edge on `cap_in` copies the channel 2 counter into the capture register (address 10) and sets the capture flag (channel 2 control bit 2). irq_req[3] is the capture flag ANDed with its enable (channel 2 control bit 3).
- R7: irq_code is 1, 2, 3 or 4 for the highest pending request in the order irq_req[0], irq_req[1], irq_req[2], irq_req[3], and 0 when none is pending.
- R8: Read data appears on `bus_rdata` one cycle after `bus_rd`. A counter read in a cycle where that counter decrements returns the value from before the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared count-enable pulse |
| bus_addr | input | 4 | Word address of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cap_in | input | 1 | Capture trigger for channel 2 |
| irq_req | output | 4 | Per-source requests: underflow 0, 1, 2, then capture |
| irq_code | output | 3 | Code of the highest-priority pending request |

## Verification
The checker examines several behaviours on every cycle. A stopped counter must hold its value, and a running counter must fall by exactly one. An underflow must reload the counter and set the flag. Reads must return the count from before that cycle's decrement. Capture must copy the right count. The top request must always win the code, and an idle request vector must give code 0. Some behaviours are shown only by the bench's scenarios. These are the resulting counts after runs of several lengths, and the clear-on-zero rule for flags. Also covered there are the ranking between lower-priority sources, and the fact that an enable-less flag stays silent.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // control word bit positions
  localparam int unsigned CTL_UFLAG = 0;
  localparam int unsigned CTL_UIEN  = 1;
  localparam int unsigned CTL_CFLAG = 2;
  localparam int unsigned CTL_CIEN  = 3;

  localparam int unsigned A_START   = 0;
  localparam int unsigned A_CAPTURE = 10;

  function automatic int unsigned a_reload(int unsigned ch);
    return 1 + 3 * ch;
  endfunction

  function automatic int unsigned a_count(int unsigned ch);
    return 2 + 3 * ch;
  endfunction

  function automatic int unsigned a_ctrl(int unsigned ch);
    return 3 + 3 * ch;
  endfunction

  // flag update: a set event wins, a written zero clears, a written one keeps
  function automatic logic flag_next(logic cur, logic set_evt, logic wr, logic wbit);
    if (set_evt)        return 1'b1;
    else if (wr && !wbit) return 1'b0;
    else                return cur;
  endfunction
endpackage

// File: rtl/cdt_channel.sv
module cdt_channel
  import cdt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         wr_reload,
  input  logic         wr_count,
  input  logic         wr_ctrl,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count_o,
  output logic [W-1:0] reload_o,
  output logic         flag_o,
  output logic         ien_o,
  output logic         uf_o
);
  function automatic logic [W-1:0] step_down(logic [W-1:0] cur, logic [W-1:0] rld);
    return (cur == '0) ? rld : cur - W'(1);
  endfunction

  logic [W-1:0] count_q, reload_q;
  logic         flag_q, ien_q;

  assign uf_o = cnt_en && (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '1;
      reload_q <= '1;
      flag_q   <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      if (wr_count)    count_q <= wdata;
      else if (cnt_en) count_q <= step_down(count_q, reload_q);
      if (wr_reload)   reload_q <= wdata;
      flag_q <= flag_next(flag_q, uf_o, wr_ctrl, wdata[CTL_UFLAG]);
      if (wr_ctrl)     ien_q <= wdata[CTL_UIEN];
    end
  end

  assign count_o  = count_q;
  assign reload_o = reload_q;
  assign flag_o   = flag_q;
  assign ien_o    = ien_q;
endmodule

// File: rtl/cdt_capture.sv
module cdt_capture
  import cdt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_in,
  input  logic [W-1:0] count_in,
  input  logic         wr_ctrl,
  input  logic         wflag_bit,
  input  logic         wien_bit,
  output logic [W-1:0] cap_val_o,
  output logic         cap_flag_o,
  output logic         cap_ien_o,
  output logic         cap_evt_o
);
  logic         cap_prev;
  logic [W-1:0] cap_q;
  logic         cflag_q, cien_q;

  assign cap_evt_o = cap_in && !cap_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_prev <= 1'b0;
      cap_q    <= '0;
      cflag_q  <= 1'b0;
      cien_q   <= 1'b0;
    end else begin
      cap_prev <= cap_in;
      if (cap_evt_o) cap_q <= count_in;
      cflag_q <= flag_next(cflag_q, cap_evt_o, wr_ctrl, wflag_bit);
      if (wr_ctrl) cien_q <= wien_bit;
    end
  end

  assign cap_val_o  = cap_q;
  assign cap_flag_o = cflag_q;
  assign cap_ien_o  = cien_q;
endmodule

// File: rtl/cdt_prio.sv
module cdt_prio #(
  parameter int unsigned NSRC   = 4,
  parameter int unsigned CODE_W = 3
) (
  input  logic [NSRC-1:0]   req,
  output logic [CODE_W-1:0] code
);
  // index 0 is the highest priority; walk from lowest so the highest wins
  always_comb begin
    code = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) code = CODE_W'(i + 1);
    end
  end
endmodule

// File: rtl/cdt_timer_unit.sv
module cdt_timer_unit
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              cap_in,
  output logic [3:0]        irq_req,
  output logic [2:0]        irq_code
);
  localparam int unsigned NCH    = 3;
  localparam int unsigned NSRC   = NCH + 1;
  localparam int unsigned CODE_W = $clog2(NSRC + 1);
  localparam int unsigned CAP_CH = NCH - 1;

  logic [NCH-1:0]            start_q;
  logic [NCH-1:0]            cnt_en, wr_reload, wr_count, wr_ctrl;
  logic [NCH-1:0][CNT_W-1:0] count_w, reload_w;
  logic [NCH-1:0]            flag_w, ien_w, uf_w;
  logic [CNT_W-1:0]          cap_val;
  logic                      cap_flag, cap_ien, cap_evt;
  logic [CNT_W-1:0]          rd_mux;
  logic                      wr_start;

  assign wr_start = bus_wr && (bus_addr == ADDR_W'(A_START));

  always_ff @(posedge clk) begin
    if (!rst_n)        start_q <= '0;
    else if (wr_start) start_q <= bus_wdata[NCH-1:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign wr_reload[g] = bus_wr && (bus_addr == ADDR_W'(a_reload(g)));
    assign wr_count[g]  = bus_wr && (bus_addr == ADDR_W'(a_count(g)));
    assign wr_ctrl[g]   = bus_wr && (bus_addr == ADDR_W'(a_ctrl(g)));
    assign cnt_en[g]    = tick && start_q[g];

    cdt_channel #(.W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_en    (cnt_en[g]),
      .wr_reload (wr_reload[g]),
      .wr_count  (wr_count[g]),
      .wr_ctrl   (wr_ctrl[g]),
      .wdata     (bus_wdata),
      .count_o   (count_w[g]),
      .reload_o  (reload_w[g]),
      .flag_o    (flag_w[g]),
      .ien_o     (ien_w[g]),
      .uf_o      (uf_w[g])
    );

    assign irq_req[g] = flag_w[g] && ien_w[g];
  end

  cdt_capture #(.W(CNT_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_in     (cap_in),
    .count_in   (count_w[CAP_CH]),
    .wr_ctrl    (wr_ctrl[CAP_CH]),
    .wflag_bit  (bus_wdata[CTL_CFLAG]),
    .wien_bit   (bus_wdata[CTL_CIEN]),
    .cap_val_o  (cap_val),
    .cap_flag_o (cap_flag),
    .cap_ien_o  (cap_ien),
    .cap_evt_o  (cap_evt)
  );

  assign irq_req[NCH] = cap_flag && cap_ien;

  cdt_prio #(.NSRC(NSRC), .CODE_W(CODE_W)) u_prio (
    .req  (irq_req),
    .code (irq_code)
  );

  // read mux sees the register values before this edge's update
  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(A_START))   rd_mux[NCH-1:0] = start_q;
    if (bus_addr == ADDR_W'(A_CAPTURE)) rd_mux = cap_val;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(a_reload(c))) rd_mux = reload_w[c];
      if (bus_addr == ADDR_W'(a_count(c)))  rd_mux = count_w[c];
      if (bus_addr == ADDR_W'(a_ctrl(c))) begin
        rd_mux[CTL_UFLAG] = flag_w[c];
        rd_mux[CTL_UIEN]  = ien_w[c];
        if (c == CAP_CH) begin
          rd_mux[CTL_CFLAG] = cap_flag;
          rd_mux[CTL_CIEN]  = cap_ien;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/cdt_timer_unit_chk.sv
module cdt_timer_unit_chk
  import cdt_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NCH    = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic [NCH-1:0]        start,
  input logic [NCH-1:0]        wr_count,
  input logic [NCH-1:0][W-1:0] count,
  input logic [NCH-1:0][W-1:0] reload,
  input logic [NCH-1:0]        uf,
  input logic [NCH-1:0]        flag,
  input logic [NCH:0]          irq_req,
  input logic [2:0]            irq_code,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [W-1:0]          bus_rdata,
  input logic                  cap_evt,
  input logic [W-1:0]          cap_val,
  input logic                  cap_flag
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!(tick && start[i]) && !wr_count[i]) |=> count[i] == $past(count[i])); // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && start[i] && !wr_count[i] && count[i] != '0) |=> count[i] == $past(count[i]) - W'(1)); // R2
    AST_UF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (uf[i] && !wr_count[i]) |=> count[i] == $past(reload[i])); // R3
    AST_UF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      uf[i] |=> flag[i]); // R3
    AST_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(a_count(i))) |=> bus_rdata == $past(count[i])); // R8
  end

  AST_PRIO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[0] |-> irq_code == 3'd1); // R7
  AST_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req == '0) |-> irq_code == 3'd0); // R7
  AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_val == $past(count[NCH-1])) && cap_flag); // R6
endmodule

bind cdt_timer_unit cdt_timer_unit_chk #(.W(CNT_W), .ADDR_W(ADDR_W), .NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .start     (start_q),
  .wr_count  (wr_count),
  .count     (count_w),
  .reload    (reload_w),
  .uf        (uf_w),
  .flag      (flag_w),
  .irq_req   (irq_req),
  .irq_code  (irq_code),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .cap_evt   (cap_evt),
  .cap_val   (cap_val),
  .cap_flag  (cap_flag)
);

// File: tb/cdt_timer_unit_bench.sv
module cdt_timer_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cap_in = 1'b0;
  logic [3:0]  irq_req;
  logic [2:0]  irq_code;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  cdt_timer_unit u_cdt_timer_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .irq_req(irq_req), .irq_code(irq_code)
  );

  // vectors: channel, reload, ticks, expected count, expected underflow flag
  localparam int NV = 5;
  localparam int VEC [NV][5] = '{
    '{0, 10,  3,   7, 0},
    '{1,  5,  6,   5, 1},
    '{2,  2,  7,   1, 1},
    '{0,  0,  4,   0, 1},
    '{1, 100, 0, 100, 0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic run_ticks(int n);
    repeat (n) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 code", 32'(irq_code), 0);
    chk("R1 req", 32'(irq_req), 0);
    rd(0, rv);  chk("R1 start", rv, 0);
    rd(2, rv);  chk("R1 count0", rv, 32'hFFFF_FFFF);
    rd(7, rv);  chk("R1 reload2", rv, 32'hFFFF_FFFF);
    rd(9, rv);  chk("R1 ctrl2", rv, 0);
    rd(10, rv); chk("R1 capture", rv, 0);

    // R2 R3 vector table
    for (int v = 0; v < NV; v++) begin
      int ch;
      ch = VEC[v][0];
      wr(0, 0);
      wr(1 + 3 * ch, VEC[v][1]);
      wr(2 + 3 * ch, VEC[v][1]);
      wr(3 + 3 * ch, 0);
      wr(0, 32'(1) << ch);
      run_ticks(VEC[v][2]);
      wr(0, 0);
      rd(2 + 3 * ch, rv); chk("R2 R3 count", rv, VEC[v][3]);
      rd(3 + 3 * ch, rv); chk("R3 flag", rv & 1, VEC[v][4]);
      chk("R5 no enable no request", 32'(irq_req), 0);
      if (v == 0) begin
        rd(5, rv); chk("R2 stopped channel holds", rv, 32'hFFFF_FFFF);
      end
    end

    // R8 read collides with a decrement
    wr(0, 0);
    wr(2, 50);
    wr(0, 1);
    @(negedge clk);
    tick = 1'b1; bus_addr = 4'd2; bus_rd = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_rd = 1'b0;
    chk("R8 pre-decrement read", bus_rdata, 50);
    rd(2, rv); chk("R8 after decrement", rv, 49);

    // R6 capture
    wr(0, 0);
    wr(8, 1234);
    @(negedge clk); cap_in = 1'b1;
    @(negedge clk); cap_in = 1'b0;
    rd(10, rv); chk("R6 capture value", rv, 1234);
    rd(9, rv);  chk("R6 capture flag", rv & 4, 4);

    // R5 R7 priorities: underflow all channels at once
    for (int c = 0; c < 3; c++) begin
      wr(1 + 3 * c, 0);
      wr(2 + 3 * c, 0);
      wr(3 + 3 * c, (c == 2) ? 32'h4 : 32'h0);
    end
    wr(0, 7);
    run_ticks(1);
    wr(0, 0);
    wr(9, 32'h7);  chk("R7 only uf2", 32'(irq_code), 3);
    wr(6, 32'h3);  chk("R7 uf1 over uf2", 32'(irq_code), 2);
    wr(3, 32'h3);  chk("R7 uf0 top", 32'(irq_code), 1);
    chk("R5 requests", 32'(irq_req), 32'h7);
    wr(3, 32'h2);  chk("R4 clear uf0", 32'(irq_code), 2);
    wr(3, 32'h3);
    rd(3, rv);     chk("R4 writing one keeps flag clear", rv, 2);
    wr(6, 32'h0);  chk("R5 uf1 disabled", 32'(irq_code), 3);
    wr(9, 32'hC);  chk("R7 capture lowest", 32'(irq_code), 4);
    chk("R6 capture request", 32'(irq_req), 32'h8);
    wr(9, 32'h8);  chk("R4 capture flag cleared", 32'(irq_code), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule